// File: doc/BRIEF.md
# Serial-Command Bus Master Bridge

This block lets a host drive a 32-bit memory-mapped bus over a plain two-wire asynchronous serial link. The host sends a short frame: an opcode byte, then a word count, then a four-byte word address, and for writes the data words. The bridge reassembles these fields, runs one request/acknowledge bus cycle per word, and for reads streams each returned word back on its transmit wire.

Inside sit a mid-bit-sampling serial receiver, a serial transmitter, the frame parser, and the bus handshake. Multi-byte fields travel most significant byte first, while each byte on the wire goes least significant bit first. The bit time is `CLK_HZ/BAUD` clock cycles, fixed by parameters.

Top module: `uart_bus_bridge`

## Requirements
- R1: While reset is held and right after it, `tx_o` is high and `bus_cyc_o`/`bus_stb_o` are low.
- R2: A received byte is one low start bit, eight data bits with bit 0 first, and one high stop bit, each lasting `CLK_HZ/BAUD` clock cycles. Each bit is sampled near its middle.
- R3: Frame opcode 0x01 is a write. It is followed by a count byte, four address bytes (most significant first), and then four data bytes per word (most significant first). Each word produces a bus cycle with `bus_we_o`=1, the address on `bus_adr_o` and the word on `bus_dat_o`.
- R4: Frame opcode 0x02 is a read. It has a count byte and four address bytes. Each word produces a bus cycle with `bus_we_o`=0, and the acknowledged `bus_dat_i` word is sent on `tx_o` as four bytes, most significant first, in the R2 format.
- R5: For a count of N (1 to 255), N bus cycles are made, and the word address rises by one for each word, wrapping at 32 bits.
- R6: `bus_cyc_o` and `bus_stb_o` stay high until `bus_ack_i`. Address, direction and write data stay unchanged while they wait.
- R7: Bytes that finish arriving while a bus cycle or a read reply is in progress are discarded.
- R8: An opcode byte other than 0x01 or 0x02 is discarded, and the bridge keeps waiting for an opcode.
- R9: A count of 0 ends the frame after the address bytes, with no bus cycle.
- R10: `tx_o` stays high except while read data is being sent back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial receive line, idles high |
| tx_o | output | 1 | Serial transmit line, idles high |
| bus_cyc_o | output | 1 | Bus cycle active |
| bus_stb_o | output | 1 | Bus request strobe |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_adr_o | output | 32 | Word address |
| bus_dat_o | output | 32 | Write data |
| bus_dat_i | input | 32 | Read data |
| bus_ack_i | input | 1 | Slave acknowledge, ends the cycle |

## Verification
Byte values such as 0x80 and 0x01 in the address and data fields show up any reversal of bit order or byte order as a wrong bus address or data word. Bursts start just below a byte boundary and at the top of the address space, so a bridge that did not carry its increment, or that skipped it, would address the wrong words. Stray bytes are sent in the middle of a read reply, and an unknown opcode is sent just before a valid frame. A bridge that accepted either would take the next real frame out of step and write the wrong location. A slow acknowledge exposes a strobe that drops early or fields that change while waiting, and a zero count exposes a spurious bus cycle.

// File: rtl/uart_bus_bridge.sv
module uart_bus_bridge #(
  parameter int CLK_HZ = 200_000_000,
  parameter int BAUD   = 115_200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_i,
  output logic        tx_o,
  output logic        bus_cyc_o,
  output logic        bus_stb_o,
  output logic        bus_we_o,
  output logic [31:0] bus_adr_o,
  output logic [31:0] bus_dat_o,
  input  logic [31:0] bus_dat_i,
  input  logic        bus_ack_i
);
  localparam int DIV  = CLK_HZ / BAUD;
  localparam int HALF = DIV / 2;
  localparam int CW   = $clog2(DIV + 1);
  localparam logic [CW-1:0] DIV_M1  = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF_M1 = CW'(HALF - 1);

  typedef enum logic [2:0] {P_CMD, P_LEN, P_ADR, P_DAT, P_BUS, P_TX} pst_t;

  // receiver
  logic          rx_m, rx_s, rx_act, rx_vld;
  logic [3:0]    rx_ph;
  logic [CW-1:0] rx_cnt;
  logic [7:0]    rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1; rx_s <= 1'b1; rx_act <= 1'b0; rx_vld <= 1'b0;
      rx_ph <= '0; rx_cnt <= '0; rx_sh <= '0;
    end else begin
      rx_m   <= rx_i;
      rx_s   <= rx_m;
      rx_vld <= 1'b0;
      if (!rx_act) begin
        if (!rx_s) begin
          rx_act <= 1'b1;
          rx_ph  <= '0;
          rx_cnt <= HALF_M1;
        end
      end else if (rx_cnt != '0) begin
        rx_cnt <= rx_cnt - 1'b1;
      end else begin
        rx_cnt <= DIV_M1;
        if (rx_ph == 4'd0) begin
          if (rx_s) rx_act <= 1'b0;
          else      rx_ph  <= 4'd1;
        end else if (rx_ph < 4'd9) begin
          rx_sh <= {rx_s, rx_sh[7:1]};
          rx_ph <= rx_ph + 4'd1;
        end else begin
          rx_act <= 1'b0;
          rx_vld <= rx_s;
        end
      end
    end
  end

  // parser and bus master
  pst_t        pst;
  logic        wr;
  logic [7:0]  cnt;
  logic [2:0]  n;
  logic [31:0] adr, dat;
  logic [3:0]  tx_left;
  logic        tx_load;

  assign tx_load   = (pst == P_TX) && (tx_left == 4'd0) && (n != 3'd4);
  assign bus_cyc_o = (pst == P_BUS);
  assign bus_stb_o = (pst == P_BUS);
  assign bus_we_o  = wr;
  assign bus_adr_o = adr;
  assign bus_dat_o = dat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pst <= P_CMD; wr <= 1'b0; cnt <= '0; n <= '0; adr <= '0; dat <= '0;
    end else begin
      case (pst)
        P_CMD: if (rx_vld) begin
          if (rx_sh == 8'h01) begin
            wr <= 1'b1; pst <= P_LEN;
          end else if (rx_sh == 8'h02) begin
            wr <= 1'b0; pst <= P_LEN;
          end
        end
        P_LEN: if (rx_vld) begin
          cnt <= rx_sh; n <= '0; pst <= P_ADR;
        end
        P_ADR: if (rx_vld) begin
          adr <= {adr[23:0], rx_sh};
          n   <= n + 3'd1;
          if (n == 3'd3) begin
            n <= '0;
            if (cnt == 8'd0) pst <= P_CMD;
            else             pst <= wr ? P_DAT : P_BUS;
          end
        end
        P_DAT: if (rx_vld) begin
          dat <= {dat[23:0], rx_sh};
          n   <= n + 3'd1;
          if (n == 3'd3) begin
            n <= '0; pst <= P_BUS;
          end
        end
        P_BUS: if (bus_ack_i) begin
          adr <= adr + 32'd1;
          cnt <= cnt - 8'd1;
          if (!wr) begin
            dat <= bus_dat_i; n <= '0; pst <= P_TX;
          end else begin
            pst <= (cnt == 8'd1) ? P_CMD : P_DAT;
          end
        end
        P_TX: if (tx_load) begin
          dat <= {dat[23:0], 8'h00};
          n   <= n + 3'd1;
        end else if (tx_left == 4'd0) begin
          n   <= '0;
          pst <= (cnt == 8'd0) ? P_CMD : P_BUS;
        end
        default: pst <= P_CMD;
      endcase
    end
  end

  // transmitter
  logic [9:0]    tx_sh;
  logic [CW-1:0] tx_div;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '1; tx_left <= '0; tx_div <= '0;
    end else if (tx_load) begin
      tx_sh   <= {1'b1, dat[31:24], 1'b0};
      tx_left <= 4'd10;
      tx_div  <= DIV_M1;
    end else if (tx_left != 4'd0) begin
      if (tx_div == '0) begin
        tx_sh   <= {1'b1, tx_sh[9:1]};
        tx_left <= tx_left - 4'd1;
        tx_div  <= DIV_M1;
      end else begin
        tx_div <= tx_div - 1'b1;
      end
    end
  end

  assign tx_o = (tx_left == 4'd0) | tx_sh[0];

  // R6
  stb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb_o && !bus_ack_i |=> bus_stb_o && $stable(bus_adr_o) && $stable(bus_we_o) && $stable(bus_dat_o));
  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stb_o && bus_ack_i |=> bus_adr_o == $past(bus_adr_o) + 32'd1);
  // R10
  tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_o |-> pst == P_TX);
  // R4
  reply_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> !bus_we_o);
  // R7
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pst == P_TX) && rx_vld |=> pst == P_TX || pst == P_BUS || pst == P_CMD);
endmodule

// File: tb/uart_bus_bridge_tb_top.sv
`timescale 1ns/1ps
module uart_bus_bridge_tb_top;
  localparam int DIV = 16;

  logic        clk = 1'b0, rst_n = 1'b0, rx = 1'b1, ack = 1'b0;
  logic        tx, cyc, stb, we;
  logic [31:0] adr, dat_o, rdat = '0;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  uart_bus_bridge #(.CLK_HZ(200_000_000), .BAUD(12_500_000)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tx_o(tx),
    .bus_cyc_o(cyc), .bus_stb_o(stb), .bus_we_o(we),
    .bus_adr_o(adr), .bus_dat_o(dat_o), .bus_dat_i(rdat), .bus_ack_i(ack));

  function automatic logic [31:0] rd_word(logic [31:0] a);
    return (a ^ 32'hC3A5_96F0) + {a[7:0], 24'h0};
  endfunction

  // bus slave model with log
  logic [31:0] log_adr [16];
  logic [31:0] log_dat [16];
  logic        log_we  [16];
  int nlog = 0, ack_delay = 0, wait_cnt = 0, unstable = 0, dropped = 0;
  logic [31:0] f_adr, f_dat;
  logic        f_we;

  initial begin
    forever begin
      @(negedge clk);
      if (ack) begin
        ack = 1'b0; wait_cnt = 0;
      end else if (stb && cyc) begin
        if (wait_cnt == 0) begin
          f_adr = adr; f_dat = dat_o; f_we = we;
        end else if (adr !== f_adr || dat_o !== f_dat || we !== f_we) unstable++;
        if (wait_cnt == ack_delay) begin
          ack = 1'b1;
          rdat = rd_word(adr);
          if (nlog < 16) begin
            log_adr[nlog] = adr; log_dat[nlog] = dat_o; log_we[nlog] = we;
          end
          nlog++;
        end else wait_cnt++;
      end else if (wait_cnt != 0) begin
        dropped++; wait_cnt = 0;
      end
    end
  end

  logic reply_win = 1'b0;
  int   bad_tx = 0;
  initial forever begin
    @(negedge clk);
    if (rst_n && !tx && !reply_win) bad_tx++;
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_byte(logic [7:0] b);
    rx = 1'b0; repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rx = b[i]; repeat (DIV) @(negedge clk);
    end
    rx = 1'b1; repeat (DIV) @(negedge clk);
  endtask

  task automatic send_hdr(logic [7:0] op, logic [7:0] len, logic [31:0] a);
    send_byte(op); send_byte(len);
    for (int i = 3; i >= 0; i--) send_byte(a[i*8 +: 8]);
  endtask

  task automatic send_word(logic [31:0] w);
    for (int i = 3; i >= 0; i--) send_byte(w[i*8 +: 8]);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    while (tx) @(negedge clk);
    repeat (DIV/2) @(negedge clk);
    chk("R4 start bit", {31'd0, tx}, 32'd0);
    for (int i = 0; i < 8; i++) begin
      repeat (DIV) @(negedge clk);
      b[i] = tx;
    end
    repeat (DIV) @(negedge clk);
    chk("R4 stop bit", {31'd0, tx}, 32'd1);
  endtask

  task automatic recv_word(output logic [31:0] w);
    logic [7:0] b;
    for (int i = 3; i >= 0; i--) begin
      recv_byte(b); w[i*8 +: 8] = b;
    end
  endtask

  task automatic settle();
    repeat (4*DIV) @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (5) @(negedge clk);
    chk("R1 tx in reset", {31'd0, tx}, 32'd1);
    chk("R1 stb in reset", {31'd0, stb}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 tx after reset", {31'd0, tx}, 32'd1);
    chk("R1 cyc after reset", {31'd0, cyc}, 32'd0);
  endtask

  task automatic t_write_single();
    int base = nlog;
    ack_delay = 0;
    send_hdr(8'h01, 8'd1, 32'h1234_5678);
    send_word(32'h0180_2C80);
    settle();
    chk("R3 write count", nlog - base, 1);
    chk("R2 R3 write address", log_adr[base], 32'h1234_5678);
    chk("R2 R3 write data", log_dat[base], 32'h0180_2C80);
    chk("R3 write direction", {31'd0, log_we[base]}, 32'd1);
  endtask

  task automatic t_read_single();
    int base = nlog;
    logic [31:0] w;
    ack_delay = 2; reply_win = 1'b1;
    fork
      send_hdr(8'h02, 8'd1, 32'h8000_0401);
      recv_word(w);
    join
    settle(); reply_win = 1'b0;
    chk("R4 read count", nlog - base, 1);
    chk("R4 read address", log_adr[base], 32'h8000_0401);
    chk("R4 read direction", {31'd0, log_we[base]}, 32'd0);
    chk("R4 reply word", w, rd_word(32'h8000_0401));
  endtask

  task automatic t_burst_write();
    int base = nlog;
    ack_delay = 3;
    send_hdr(8'h01, 8'd3, 32'h0000_00FE);
    send_word(32'hA1B2_C3D4);
    send_word(32'h0000_0001);
    send_word(32'h8000_0000);
    settle();
    chk("R5 burst write count", nlog - base, 3);
    chk("R5 burst addr 0", log_adr[base],   32'h0000_00FE);
    chk("R5 burst addr 1", log_adr[base+1], 32'h0000_00FF);
    chk("R5 burst addr 2", log_adr[base+2], 32'h0000_0100);
    chk("R5 burst data 0", log_dat[base],   32'hA1B2_C3D4);
    chk("R5 burst data 1", log_dat[base+1], 32'h0000_0001);
    chk("R5 burst data 2", log_dat[base+2], 32'h8000_0000);
    chk("R6 fields stable while waiting", unstable, 0);
    chk("R6 strobe held until ack", dropped, 0);
  endtask

  task automatic t_burst_read();
    int base = nlog;
    logic [31:0] w0, w1;
    ack_delay = 1; reply_win = 1'b1;
    fork
      send_hdr(8'h02, 8'd2, 32'hFFFF_FFFF);
      begin recv_word(w0); recv_word(w1); end
    join
    settle(); reply_win = 1'b0;
    chk("R5 burst read count", nlog - base, 2);
    chk("R5 read wrap addr 0", log_adr[base],   32'hFFFF_FFFF);
    chk("R5 read wrap addr 1", log_adr[base+1], 32'h0000_0000);
    chk("R5 R4 reply word 0", w0, rd_word(32'hFFFF_FFFF));
    chk("R5 R4 reply word 1", w1, rd_word(32'h0000_0000));
  endtask

  task automatic t_bad_cmd();
    int base = nlog;
    ack_delay = 0;
    send_byte(8'h7E);
    send_hdr(8'h01, 8'd1, 32'h0000_0055);
    send_word(32'h0A0B_0C0D);
    settle();
    chk("R8 count after unknown opcode", nlog - base, 1);
    chk("R8 address after unknown opcode", log_adr[base], 32'h0000_0055);
    chk("R8 data after unknown opcode", log_dat[base], 32'h0A0B_0C0D);
  endtask

  task automatic t_busy_discard();
    int base = nlog;
    logic [31:0] w;
    ack_delay = 0; reply_win = 1'b1;
    fork
      begin
        send_hdr(8'h02, 8'd1, 32'h0000_0300);
        repeat (30) @(negedge clk);
        send_byte(8'h01);
        send_byte(8'h02);
      end
      recv_word(w);
    join
    settle(); reply_win = 1'b0;
    send_hdr(8'h01, 8'd1, 32'h0000_0077);
    send_word(32'h5566_7788);
    settle();
    chk("R7 reply word", w, rd_word(32'h0000_0300));
    chk("R7 access count", nlog - base, 2);
    chk("R7 next frame address", log_adr[base+1], 32'h0000_0077);
    chk("R7 next frame data", log_dat[base+1], 32'h5566_7788);
  endtask

  task automatic t_zero_len();
    int base = nlog;
    send_hdr(8'h01, 8'd0, 32'h0000_0099);
    settle();
    chk("R9 no access for zero count", nlog - base, 0);
    send_hdr(8'h01, 8'd1, 32'h0000_00AA);
    send_word(32'h1357_9BDF);
    settle();
    chk("R9 next frame address", log_adr[base], 32'h0000_00AA);
    chk("R9 next frame data", log_dat[base], 32'h1357_9BDF);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_write_single();
    t_read_single();
    t_burst_write();
    t_burst_read();
    t_bad_cmd();
    t_busy_discard();
    t_zero_len();
    chk("R10 tx high outside replies", bad_tx, 0);
    summary();
  end
endmodule